// File: doc/BRIEF.md
# Address-Paced Processor Clock Enable Generator

This block produces the clock enable that paces an 8-bit processor core running from a fast master clock. Software picks one of ten full-speed steps. Step k makes every processor cycle last `11 - k` master clocks. With a 10 MHz master clock, step 10 runs the core at 10 MHz and step 1 runs it at 1 MHz.

Any cycle whose address falls in the expansion-slot and I/O window (0xC000 to 0xCFFF) is stretched to ten master clocks, the 1 MHz-equivalent rate. This keeps slow peripheral cards and cycle-counted delay loops working. A global slow input forces every cycle to that rate, whatever the address.

A new cycle starts on the master clock that follows a `cpu_ce` pulse, or on the first clock after reset. The block samples the address, the slow input and the stored step only on that first clock, and the cycle keeps that length to its end. As a result, no shortened enable period is ever produced. `slow_active` marks every clock of a stretched cycle.

Top module: `cpu_clk_pacer`

## Requirements
- R1: After reset the stored step is 10. With an address outside the window and `slow_force` low, `cpu_ce` is high on every master clock and `slow_active` is low.
- R2: With step k (1 to 10), an address outside 0xC000–0xCFFF and `slow_force` low, each cycle lasts `11 - k` master clocks. `cpu_ce` is high on the last of them only, and `slow_active` stays low.
- R3: A cycle whose first-clock address has bits [15:12] equal to 4'b1100 lasts exactly 10 master clocks, whatever the step, and `slow_active` is high on all ten. Addresses 0xBFFF and 0xD000 give full-speed cycles.
- R4: A cycle that starts while `slow_force` is high lasts 10 master clocks with `slow_active` high on all ten, whatever the address and step.
- R5: A clock edge with `step_wr_en` high stores `step_wr_data` when that value is in 1..10. The values 0 and 11..15 are ignored, and the previous step stays in force.
- R6: A step write that lands after the first clock of a cycle leaves that cycle's length unchanged. The new step applies from the next cycle.
- R7: Changes to `cpu_addr` or `slow_force` after the first clock of a cycle change neither that cycle's length nor its `slow_active` value. They take effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address for the current bus cycle |
| step_wr_en | input | 1 | Write strobe for the speed step register |
| step_wr_data | input | 4 | Requested speed step, valid range 1 to 10 |
| slow_force | input | 1 | Forces every cycle to the slow rate |
| cpu_ce | output | 1 | Processor clock enable, one master clock per cycle |
| slow_active | output | 1 | High on every clock of a stretched cycle |

## Verification
The outputs depend on the address and the slow input combinationally in the first clock of a cycle. After that they come from registers, so a new address shows up in the cycle that begins on the clock after the next `cpu_ce` pulse. A step write shows up one edge later, in the first cycle that starts after the write edge. The bench drives inputs on falling edges and samples both outputs on each falling edge before it drives anything. Each measurement first waits for one full `cpu_ce` boundary, so the cycle it counts always began after the stimulus settled. Mid-cycle changes are driven on the second sample of a counted cycle, which lies after that cycle's decode clock; they are then expected one cycle later.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    // Number of programmable full-speed steps; step k divides by (NUM_STEPS + 1 - k).
    localparam int NUM_STEPS = 10;
    // Master clocks in one stretched (compatible-rate) cycle.
    localparam int SLOW_LEN  = 10;
    localparam int ADDR_W    = 16;
    localparam int STEP_W    = $clog2(NUM_STEPS + 1);
    localparam int MAX_LEN   = (NUM_STEPS > SLOW_LEN) ? NUM_STEPS : SLOW_LEN;
    localparam int LEN_W     = $clog2(MAX_LEN + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;
    typedef logic [LEN_W-1:0]  len_t;

    // What the timer needs to run one processor cycle.
    typedef struct packed {
        len_t len;
        logic slow;
    } cycle_plan_t;

    function automatic logic step_in_range(input step_t s);
        return (s >= step_t'(1)) && (s <= step_t'(NUM_STEPS));
    endfunction

    function automatic len_t step_to_len(input step_t s);
        return len_t'(NUM_STEPS + 1) - len_t'(s);
    endfunction

endpackage

// File: rtl/pacer_step_reg.sv
module pacer_step_reg
    import pacer_pkg::*;
#(
    parameter int RESET_STEP = NUM_STEPS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  step_t wr_data,
    output step_t step_q
);

    logic accept;

    always_comb begin
        accept = wr_en && step_in_range(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= step_t'(RESET_STEP);
        end else if (accept) begin
            step_q <= wr_data;
        end
    end

endmodule

// File: rtl/pacer_window_dec.sv
module pacer_window_dec
    import pacer_pkg::*;
#(
    parameter int    WIN_BITS = 12,
    parameter addr_t WIN_BASE = 16'hC000
) (
    input  addr_t addr,
    output logic  hit
);

    localparam int TAG_W = ADDR_W - WIN_BITS;

    logic [TAG_W-1:0] tag;
    logic [TAG_W-1:0] base_tag;

    generate
        if (TAG_W > 0) begin : g_tag
            always_comb begin
                tag      = addr[ADDR_W-1:WIN_BITS];
                base_tag = WIN_BASE[ADDR_W-1:WIN_BITS];
                hit      = (tag == base_tag);
            end
        end else begin : g_all
            always_comb begin
                tag      = '0;
                base_tag = '0;
                hit      = 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/pacer_cycle_timer.sv
module pacer_cycle_timer
    import pacer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cycle_plan_t plan_in,
    output logic        cpu_ce,
    output logic        slow_active
);

    len_t        phase_q;
    cycle_plan_t plan_q;
    cycle_plan_t cur_plan;
    logic        first_clk;

    always_comb begin
        first_clk   = (phase_q == '0);
        cur_plan    = first_clk ? plan_in : plan_q;
        cpu_ce      = (phase_q == (cur_plan.len - len_t'(1)));
        slow_active = cur_plan.slow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= '0;
            plan_q.len  <= len_t'(1);
            plan_q.slow <= 1'b0;
        end else begin
            if (first_clk) begin
                plan_q <= plan_in;
            end
            if (cpu_ce) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + len_t'(1);
            end
        end
    end

endmodule

// File: rtl/cpu_clk_pacer.sv
module cpu_clk_pacer
    import pacer_pkg::*;
#(
    parameter int    WIN_BITS   = 12,
    parameter addr_t WIN_BASE   = 16'hC000,
    parameter int    RESET_STEP = NUM_STEPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              step_wr_en,
    input  logic [STEP_W-1:0] step_wr_data,
    input  logic              slow_force,
    output logic              cpu_ce,
    output logic              slow_active
);

    step_t       step_q;
    logic        win_hit;
    cycle_plan_t next_plan;

    pacer_step_reg #(
        .RESET_STEP (RESET_STEP)
    ) u_step (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (step_wr_en),
        .wr_data (step_wr_data),
        .step_q  (step_q)
    );

    pacer_window_dec #(
        .WIN_BITS (WIN_BITS),
        .WIN_BASE (WIN_BASE)
    ) u_win (
        .addr (cpu_addr),
        .hit  (win_hit)
    );

    always_comb begin
        next_plan.slow = slow_force || win_hit;
        next_plan.len  = next_plan.slow ? len_t'(SLOW_LEN) : step_to_len(step_q);
    end

    pacer_cycle_timer u_timer (
        .clk         (clk),
        .rst         (rst),
        .plan_in     (next_plan),
        .cpu_ce      (cpu_ce),
        .slow_active (slow_active)
    );

endmodule

// File: rtl/pacer_checker.sv
module pacer_checker
    import pacer_pkg::*;
#(
    parameter int    WIN_BITS = 12,
    parameter addr_t WIN_BASE = 16'hC000
) (
    input logic  clk,
    input logic  rst,
    input addr_t cpu_addr,
    input logic  slow_force,
    input step_t step_q,
    input logic  cpu_ce,
    input logic  slow_active
);

    // Clocks since the last enable pulse, kept apart from the design's own counter.
    len_t gap_q;
    len_t exp_q;
    logic in_win;

    always_comb begin
        in_win = (cpu_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
            exp_q <= len_t'(1);
        end else begin
            if (gap_q == '0) begin
                exp_q <= len_t'(NUM_STEPS + 1) - len_t'(step_q);
            end
            gap_q <= cpu_ce ? '0 : gap_q + len_t'(1);
        end
    end

    p_step_legal_r5: assert property (@(posedge clk) disable iff (rst)
        (step_q >= step_t'(1)) && (step_q <= step_t'(NUM_STEPS)));

    p_fast_len_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_ce && !slow_active && gap_q != '0) |-> (gap_q == exp_q - len_t'(1)));

    p_fast_single_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_ce && !slow_active && gap_q == '0) |-> (step_q == step_t'(NUM_STEPS)));

    p_slow_len_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_ce && slow_active) |-> (gap_q == len_t'(SLOW_LEN - 1)));

    p_window_slow_r3: assert property (@(posedge clk) disable iff (rst)
        (gap_q == '0 && in_win) |-> slow_active);

    p_force_slow_r4: assert property (@(posedge clk) disable iff (rst)
        (gap_q == '0 && slow_force) |-> slow_active);

    p_gap_bound_r6: assert property (@(posedge clk) disable iff (rst)
        gap_q <= len_t'(MAX_LEN - 1));

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (gap_q != '0) |-> $stable(slow_active));

endmodule

bind cpu_clk_pacer pacer_checker #(
    .WIN_BITS (WIN_BITS),
    .WIN_BASE (WIN_BASE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_addr    (cpu_addr),
    .slow_force  (slow_force),
    .step_q      (step_q),
    .cpu_ce      (cpu_ce),
    .slow_active (slow_active)
);

// File: tb/cpu_clk_pacer_tb.sv
module cpu_clk_pacer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic        step_wr_en = 1'b0;
    logic [3:0]  step_wr_data = 4'd0;
    logic        slow_force = 1'b0;
    logic        cpu_ce;
    logic        slow_active;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    cpu_clk_pacer u_dut (
        .clk          (clk),
        .rst          (rst),
        .cpu_addr     (cpu_addr),
        .step_wr_en   (step_wr_en),
        .step_wr_data (step_wr_data),
        .slow_force   (slow_force),
        .cpu_ce       (cpu_ce),
        .slow_active  (slow_active)
    );

    // Vector fields: force[25] addr[24:9] step[8:5] len[4:1] slow[0]
    localparam int NVEC = 12;
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b0, 16'h0000, 4'd10, 4'd1,  1'b0},
        {1'b0, 16'h0100, 4'd1,  4'd10, 1'b0},
        {1'b0, 16'h8000, 4'd5,  4'd6,  1'b0},
        {1'b0, 16'hFFFF, 4'd9,  4'd2,  1'b0},
        {1'b0, 16'h2345, 4'd2,  4'd9,  1'b0},
        {1'b0, 16'hC000, 4'd7,  4'd10, 1'b1},
        {1'b0, 16'hCFFF, 4'd7,  4'd10, 1'b1},
        {1'b0, 16'hC0E8, 4'd10, 4'd10, 1'b1},
        {1'b0, 16'hBFFF, 4'd7,  4'd4,  1'b0},
        {1'b0, 16'hD000, 4'd7,  4'd4,  1'b0},
        {1'b1, 16'h0000, 4'd3,  4'd10, 1'b1},
        {1'b1, 16'hE000, 4'd10, 4'd10, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_step(input logic [3:0] v);
        @(negedge clk);
        step_wr_en   = 1'b1;
        step_wr_data = v;
        @(negedge clk);
        step_wr_en   = 1'b0;
    endtask

    // Waits for a cycle boundary, then counts the next whole cycle.
    // op 1: write step, op 2: set address, op 3: set slow_force, done on sample act_at.
    task automatic run_cycle(input int act_at, input int op, input logic [15:0] val,
                             output int len, output int slow_cnt);
        int  guard;
        bit  ce_s;
        len      = 0;
        slow_cnt = 0;
        guard    = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!cpu_ce && guard < 64);
        do begin
            @(negedge clk);
            ce_s = cpu_ce;
            if (slow_active) slow_cnt++;
            step_wr_en = 1'b0;
            if (len == act_at) begin
                case (op)
                    1: begin step_wr_en = 1'b1; step_wr_data = val[3:0]; end
                    2: cpu_addr = val;
                    3: slow_force = val[0];
                    default: ;
                endcase
            end
            len++;
        end while (!ce_s && len < 64);
        step_wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int len;
        int sc;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(cpu_ce == 1'b1, "R1 ce after reset", int'(cpu_ce), 1);
        check(slow_active == 1'b0, "R1 slow after reset", int'(slow_active), 0);
        run_cycle(-1, 0, 16'h0, len, sc);
        check(len == 1, "R1 period after reset", len, 1);

        // Table: R2 step periods, R3 window and edges, R4 forced slow
        for (int i = 0; i < NVEC; i++) begin
            write_step(VEC[i][8:5]);
            slow_force = VEC[i][25];
            cpu_addr   = VEC[i][24:9];
            for (int r = 0; r < 2; r++) begin
                run_cycle(-1, 0, 16'h0, len, sc);
                check(len == int'(VEC[i][4:1]), "R2/R3/R4 cycle length", len, int'(VEC[i][4:1]));
                check(sc == (VEC[i][0] ? len : 0), "R2/R3/R4 slow flag clocks", sc,
                      VEC[i][0] ? len : 0);
            end
        end
        slow_force = 1'b0;
        cpu_addr   = 16'h1000;

        // R5: out-of-range writes ignored
        write_step(4'd4);
        run_cycle(-1, 0, 16'h0, len, sc);
        check(len == 7, "R5 valid step 4", len, 7);
        write_step(4'd0);
        run_cycle(-1, 0, 16'h0, len, sc);
        check(len == 7, "R5 write 0 ignored", len, 7);
        write_step(4'd11);
        run_cycle(-1, 0, 16'h0, len, sc);
        check(len == 7, "R5 write 11 ignored", len, 7);
        write_step(4'd15);
        run_cycle(-1, 0, 16'h0, len, sc);
        check(len == 7, "R5 write 15 ignored", len, 7);

        // R6: step change mid-cycle takes effect next cycle
        write_step(4'd1);
        run_cycle(1, 1, 16'd10, len, sc);
        check(len == 10, "R6 current cycle kept", len, 10);
        run_cycle(-1, 0, 16'h0, len, sc);
        check(len == 1, "R6 next cycle uses new step", len, 1);

        // R7: address change mid-cycle
        write_step(4'd1);
        cpu_addr = 16'h0000;
        run_cycle(1, 2, 16'hC010, len, sc);
        check(len == 10 && sc == 0, "R7 addr change ignored in cycle", sc, 0);
        run_cycle(-1, 0, 16'h0, len, sc);
        check(sc == 10, "R7 window applies next cycle", sc, 10);

        // R7: leaving the window mid-cycle keeps the stretch
        write_step(4'd10);
        cpu_addr = 16'hC800;
        run_cycle(1, 2, 16'h0400, len, sc);
        check(len == 10 && sc == 10, "R7 slow cycle held", len, 10);
        run_cycle(-1, 0, 16'h0, len, sc);
        check(len == 1 && sc == 0, "R7 fast after leaving window", len, 1);

        // R7: slow_force raised mid-cycle
        write_step(4'd6);
        cpu_addr = 16'h0000;
        run_cycle(1, 3, 16'h1, len, sc);
        check(len == 5 && sc == 0, "R7 force ignored in cycle", len, 5);
        run_cycle(-1, 0, 16'h0, len, sc);
        check(len == 10 && sc == 10, "R7 force applies next cycle", len, 10);
        slow_force = 1'b0;

        // R1: reset mid-run restores step 10
        write_step(4'd2);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cpu_ce == 1'b1 && slow_active == 1'b0, "R1 re-reset state", int'(cpu_ce), 1);
        run_cycle(-1, 0, 16'h0, len, sc);
        check(len == 1, "R1 step reset to 10", len, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule